// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block decides which pending interrupt source a small processor core services next. Each source has a request flag, an enable bit and a priority bit that places it on the low or the high level. A global enable gates all of them. At every instruction boundary the core raises a poll strobe. If a source is eligible and its level is not blocked by a routine already in service, the controller accepts it. It then runs a hardware call: it writes both bytes of the current program counter to a byte-wide stack, low byte first, and hands the core the source's vector address to load. During this call it also pulses a per-source acknowledge, so that request flags which hardware clears can be reset.

The controller records which priority levels are in service. A high-level routine may interrupt a low-level one. Nothing interrupts a high-level routine, and a second low-level request cannot nest inside a low-level routine. Two return strobes exist. Both pop the saved program counter back to the core. Only the interrupt-return clears the in-service mark of the level being left. A plain return leaves that mark set, so the controller keeps blocking the same and lower levels. Only the program counter is saved. Status words and registers belong to the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source is accepted only in a cycle where poll_i is 1, no call or return sequence is running, and its request, its enable bit and glb_en_i are all 1.
- R2: The high level (prio_i bit = 1) beats the low level. Within a level, the source with the lowest bit index wins, so bit 0 has the highest precedence.
- R3: An acceptance produces a single-cycle one-hot pulse on ack_o, at the bit of the winning source, in the cycle after the poll.
- R4: The call writes to the stack on two consecutive cycles, beginning in the cycle after acceptance. It writes PC[7:0] to address SP+1 and then PC[15:8] to address SP+2, and SP ends 2 higher.
- R5: In the second write cycle, pc_load_o is 1 and pc_val_o carries the vector 0x0003 + 8 × (winning bit index).
- R6: If the high level is in service (insvc_o bit 1), no source is accepted. If only the low level is in service (insvc_o bit 0), only high-level sources are accepted. An acceptance sets the bit of the accepted level.
- R7: An interrupt-return strobe (reti_i) reads the byte at SP as PC[15:8], then reads SP-1 as PC[7:0]. In the second read cycle it asserts pc_load_o with that value, and SP ends 2 lower. It clears the highest set in-service bit in the cycle after the strobe.
- R8: A plain return strobe (ret_i) performs the same two reads and the same load, but leaves insvc_o unchanged.
- R9: While busy_o is 1, poll_i, ret_i and reti_i are ignored.
- R10: After reset, SP equals SP_INIT (7), insvc_o is 0, busy_o is 0, ack_o is 0, and there are no stack strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NSRC | Request flag per source |
| src_en_i | input | NSRC | Enable bit per source |
| prio_i | input | NSRC | Priority level per source (1 = high) |
| glb_en_i | input | 1 | Global interrupt enable |
| poll_i | input | 1 | Instruction boundary; interrupts may be taken |
| pc_i | input | PC_W | Program counter to save on a call |
| ret_i | input | 1 | Plain return strobe |
| reti_i | input | 1 | Interrupt-return strobe |
| stk_rdata_i | input | PC_W/2 | Stack read data (combinational from stk_addr_o) |
| stk_we_o | output | 1 | Stack write strobe |
| stk_re_o | output | 1 | Stack read strobe |
| stk_addr_o | output | SP_W | Stack byte address |
| stk_wdata_o | output | PC_W/2 | Stack write data |
| pc_load_o | output | 1 | Core must load pc_val_o |
| pc_val_o | output | PC_W | Vector or restored program counter |
| ack_o | output | NSRC | One-cycle acknowledge per source |
| busy_o | output | 1 | Call or return sequence in progress |
| insvc_o | output | 2 | In-service flags: bit 1 high level, bit 0 low level |
| sp_o | output | SP_W | Current stack pointer |

## Verification
A wrong in-service bit shows up at the next poll. A source that should be blocked gets an acknowledge, or a permitted preemption gets none, one cycle after poll_i. A wrong bit also shows directly on insvc_o in the cycle after the strobe that changed it. A stack pointer that is off by one shows on stk_addr_o during the first write or read of the next sequence, and a return that pops the wrong bytes shows on pc_val_o two cycles after the strobe. The bench exercises an interleaving of low service, high preemption, a plain return and interrupt-returns, so a bit cleared on the wrong return changes an acknowledge within one poll.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_PUSH_LO,
      SQ_PUSH_HI,
      SQ_POP_HI,
      SQ_POP_LO
   } seq_state_e;

   localparam int unsigned NUM_LVL = 2;
   localparam int unsigned LVL_LO  = 0;
   localparam int unsigned LVL_HI  = 1;

endpackage

// File: rtl/irq_level_pick.sv
// Fixed-order picker: the lowest set index among the candidates wins.
module irq_level_pick #(
   parameter int unsigned NSRC = 6,
   parameter int unsigned IDXW = 3
) (
   input  logic [NSRC-1:0] cand_i,
   output logic            hit_o,
   output logic [IDXW-1:0] idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (cand_i[i]) idx_o = IDXW'(i);
      end
      hit_o = |cand_i;
   end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_prio_pkg::*;
#(
   parameter int unsigned NSRC = 6,
   parameter int unsigned IDXW = 3
) (
   input  logic [NSRC-1:0]    req_i,
   input  logic [NSRC-1:0]    src_en_i,
   input  logic [NSRC-1:0]    prio_i,
   input  logic               glb_en_i,
   input  logic [NUM_LVL-1:0] insvc_i,
   output logic               grant_vld_o,
   output logic [IDXW-1:0]    grant_idx_o,
   output logic               grant_lvl_o
);

   logic [NSRC-1:0]              elig;
   logic [NUM_LVL-1:0]           lvl_hit;
   logic [NUM_LVL-1:0][IDXW-1:0] lvl_idx;
   logic [NUM_LVL-1:0]           lvl_open;

   assign elig = req_i & src_en_i & {NSRC{glb_en_i}};

   for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
      logic [NSRC-1:0] cand;
      if (g == LVL_HI) begin : g_hi
         assign cand = elig & prio_i;
      end else begin : g_lo
         assign cand = elig & ~prio_i;
      end
      irq_level_pick #(.NSRC(NSRC), .IDXW(IDXW)) u_pick (
         .cand_i (cand),
         .hit_o  (lvl_hit[g]),
         .idx_o  (lvl_idx[g])
      );
   end

   // A level is open when no level at or above it is in service.
   assign lvl_open[LVL_HI] = ~insvc_i[LVL_HI];
   assign lvl_open[LVL_LO] = ~insvc_i[LVL_HI] & ~insvc_i[LVL_LO];

   always_comb begin
      grant_vld_o = 1'b0;
      grant_idx_o = '0;
      grant_lvl_o = 1'b0;
      if (lvl_hit[LVL_HI] && lvl_open[LVL_HI]) begin
         grant_vld_o = 1'b1;
         grant_idx_o = lvl_idx[LVL_HI];
         grant_lvl_o = 1'b1;
      end else if (lvl_hit[LVL_LO] && lvl_open[LVL_LO]) begin
         grant_vld_o = 1'b1;
         grant_idx_o = lvl_idx[LVL_LO];
      end
   end

endmodule

// File: rtl/irq_insvc.sv
module irq_insvc
   import irq_prio_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en_i,
   input  logic               set_lvl_i,
   input  logic               clr_en_i,
   output logic [NUM_LVL-1:0] insvc_o
);

   logic [NUM_LVL-1:0] insvc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         insvc_q <= '0;
      end else if (clr_en_i) begin
         if (insvc_q[LVL_HI]) insvc_q[LVL_HI] <= 1'b0;
         else                 insvc_q[LVL_LO] <= 1'b0;
      end else if (set_en_i) begin
         if (set_lvl_i) insvc_q[LVL_HI] <= 1'b1;
         else           insvc_q[LVL_LO] <= 1'b1;
      end
   end

   assign insvc_o = insvc_q;

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
   import irq_prio_pkg::*;
#(
   parameter int unsigned PC_W    = 16,
   parameter int unsigned SP_W    = 8,
   parameter int unsigned SP_INIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_go_i,
   input  logic              ret_go_i,
   input  logic [PC_W-1:0]   call_pc_i,
   input  logic [PC_W-1:0]   call_vec_i,
   input  logic [PC_W/2-1:0] rdata_i,
   output logic              busy_o,
   output logic              we_o,
   output logic              re_o,
   output logic [SP_W-1:0]   addr_o,
   output logic [PC_W/2-1:0] wdata_o,
   output logic              pc_load_o,
   output logic [PC_W-1:0]   pc_val_o,
   output logic [SP_W-1:0]   sp_o
);

   localparam int unsigned BW = PC_W / 2;

   seq_state_e      st_q, st_d;
   logic [SP_W-1:0] sp_q;
   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] vec_q;
   logic [BW-1:0]   hi_q;
   logic            push_ph, pop_ph;

   assign push_ph = (st_q == SQ_PUSH_LO) || (st_q == SQ_PUSH_HI);
   assign pop_ph  = (st_q == SQ_POP_HI)  || (st_q == SQ_POP_LO);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SQ_IDLE: begin
            if (ret_go_i)       st_d = SQ_POP_HI;
            else if (call_go_i) st_d = SQ_PUSH_LO;
         end
         SQ_PUSH_LO: st_d = SQ_PUSH_HI;
         SQ_PUSH_HI: st_d = SQ_IDLE;
         SQ_POP_HI:  st_d = SQ_POP_LO;
         SQ_POP_LO:  st_d = SQ_IDLE;
         default:    st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         sp_q  <= SP_W'(SP_INIT);
         pc_q  <= '0;
         vec_q <= '0;
         hi_q  <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == SQ_IDLE && call_go_i && !ret_go_i) begin
            pc_q  <= call_pc_i;
            vec_q <= call_vec_i;
         end
         if (push_ph) sp_q <= sp_q + 1'b1;
         if (pop_ph)  sp_q <= sp_q - 1'b1;
         if (st_q == SQ_POP_HI) hi_q <= rdata_i;
      end
   end

   always_comb begin
      busy_o    = (st_q != SQ_IDLE);
      we_o      = push_ph;
      re_o      = pop_ph;
      addr_o    = push_ph ? sp_q + 1'b1 : sp_q;
      wdata_o   = (st_q == SQ_PUSH_HI) ? pc_q[PC_W-1:BW] : pc_q[BW-1:0];
      pc_load_o = (st_q == SQ_PUSH_HI) || (st_q == SQ_POP_LO);
      pc_val_o  = (st_q == SQ_PUSH_HI) ? vec_q : {hi_q, rdata_i};
   end

   assign sp_o = sp_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int unsigned NSRC     = 6,
   parameter int unsigned PC_W     = 16,
   parameter int unsigned SP_W     = 8,
   parameter int unsigned SP_INIT  = 7,
   parameter int unsigned VEC_BASE = 3,
   parameter int unsigned VEC_STEP = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   req_i,
   input  logic [NSRC-1:0]   src_en_i,
   input  logic [NSRC-1:0]   prio_i,
   input  logic              glb_en_i,
   input  logic              poll_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic              ret_i,
   input  logic              reti_i,
   input  logic [PC_W/2-1:0] stk_rdata_i,
   output logic              stk_we_o,
   output logic              stk_re_o,
   output logic [SP_W-1:0]   stk_addr_o,
   output logic [PC_W/2-1:0] stk_wdata_o,
   output logic              pc_load_o,
   output logic [PC_W-1:0]   pc_val_o,
   output logic [NSRC-1:0]   ack_o,
   output logic              busy_o,
   output logic [1:0]        insvc_o
,  output logic [SP_W-1:0]   sp_o
);

   localparam int unsigned IDXW    = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam longint      VEC_TOP = longint'(VEC_BASE) + longint'(VEC_STEP) * longint'(NSRC - 1);

   initial begin
      assert (NSRC >= 1 && NSRC <= 32) else $error("NSRC out of range");
      assert (PC_W % 2 == 0 && PC_W >= 2) else $error("PC_W must be even");
      assert (VEC_TOP < (longint'(1) << PC_W)) else $error("vector table exceeds PC_W");
      assert (SP_INIT < (longint'(1) << SP_W)) else $error("SP_INIT exceeds SP_W");
   end

   logic            grant_vld, grant_lvl;
   logic [IDXW-1:0] grant_idx;
   logic            idle, ret_go, call_go, clr_go;
   logic [PC_W-1:0] vec;
   logic [NSRC-1:0] ack_q;

   irq_arbiter #(.NSRC(NSRC), .IDXW(IDXW)) u_arb (
      .req_i       (req_i),
      .src_en_i    (src_en_i),
      .prio_i      (prio_i),
      .glb_en_i    (glb_en_i),
      .insvc_i     (insvc_o),
      .grant_vld_o (grant_vld),
      .grant_idx_o (grant_idx),
      .grant_lvl_o (grant_lvl)
   );

   assign idle    = ~busy_o;
   assign ret_go  = idle & (ret_i | reti_i);
   assign call_go = idle & poll_i & grant_vld & ~ret_go;
   assign clr_go  = idle & reti_i;
   assign vec     = PC_W'(VEC_BASE) + PC_W'(VEC_STEP) * PC_W'(grant_idx);

   irq_insvc u_insvc (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en_i  (call_go),
      .set_lvl_i (grant_lvl),
      .clr_en_i  (clr_go),
      .insvc_o   (insvc_o)
   );

   irq_stack_seq #(.PC_W(PC_W), .SP_W(SP_W), .SP_INIT(SP_INIT)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .call_go_i  (call_go),
      .ret_go_i   (ret_go),
      .call_pc_i  (pc_i),
      .call_vec_i (vec),
      .rdata_i    (stk_rdata_i),
      .busy_o     (busy_o),
      .we_o       (stk_we_o),
      .re_o       (stk_re_o),
      .addr_o     (stk_addr_o),
      .wdata_o    (stk_wdata_o),
      .pc_load_o  (pc_load_o),
      .pc_val_o   (pc_val_o),
      .sp_o       (sp_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= '0;
      else        ack_q <= call_go ? ({{(NSRC-1){1'b0}}, 1'b1} << grant_idx) : '0;
   end

   assign ack_o = ack_q;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int unsigned NSRC = 6,
   parameter int unsigned SP_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] prio_i,
   input logic            ret_i,
   input logic            reti_i,
   input logic            stk_we_o,
   input logic            stk_re_o,
   input logic            pc_load_o,
   input logic [NSRC-1:0] ack_o,
   input logic            busy_o,
   input logic [1:0]      insvc_o,
   input logic [SP_W-1:0] sp_o
);

   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_o)); // R3
   AST_ACK_WITH_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_o) |-> (stk_we_o && busy_o)); // R4
   AST_PUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_we_o && !$past(stk_we_o)) |=> stk_we_o); // R4
   AST_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      stk_we_o |=> (sp_o == $past(sp_o) + 1'b1)); // R4
   AST_HI_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ack_o & $past(prio_i))) |-> !$past(insvc_o[1])); // R6
   AST_LO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ack_o & ~$past(prio_i))) |-> ($past(insvc_o) == 2'b00)); // R6
   AST_PLAIN_RET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !reti_i && !busy_o) |=> $stable(insvc_o)); // R8
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(insvc_o)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!stk_we_o && !stk_re_o && !pc_load_o)); // R5

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .SP_W(SP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .prio_i    (prio_i),
   .ret_i     (ret_i),
   .reti_i    (reti_i),
   .stk_we_o  (stk_we_o),
   .stk_re_o  (stk_re_o),
   .pc_load_o (pc_load_o),
   .ack_o     (ack_o),
   .busy_o    (busy_o),
   .insvc_o   (insvc_o),
   .sp_o      (sp_o)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  req = '0, en = '0, prio = '0;
   logic        glb = 1'b0, poll = 1'b0, ret = 1'b0, reti = 1'b0;
   logic [15:0] pc = '0;
   logic [7:0]  rdata;
   logic        we, re, pc_load, busy;
   logic [7:0]  addr, wdata, sp;
   logic [15:0] pc_val;
   logic [5:0]  ack;
   logic [1:0]  insvc;
   logic [7:0]  mem [256];
   int          n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   irq_prio_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .src_en_i(en), .prio_i(prio),
      .glb_en_i(glb), .poll_i(poll), .pc_i(pc), .ret_i(ret), .reti_i(reti),
      .stk_rdata_i(rdata), .stk_we_o(we), .stk_re_o(re), .stk_addr_o(addr),
      .stk_wdata_o(wdata), .pc_load_o(pc_load), .pc_val_o(pc_val), .ack_o(ack),
      .busy_o(busy), .insvc_o(insvc), .sp_o(sp)
   );

   assign rdata = mem[addr];
   always @(posedge clk) if (we) mem[addr] <= wdata;

   // {glb, en, prio, req, expected ack}
   localparam logic [24:0] TBL [10] = '{
      {1'b1, 6'h3F, 6'h00, 6'h3F, 6'h01},
      {1'b1, 6'h3F, 6'h00, 6'h30, 6'h10},
      {1'b1, 6'h3F, 6'h20, 6'h3F, 6'h20},
      {1'b1, 6'h3F, 6'h0C, 6'h0E, 6'h04},
      {1'b0, 6'h3F, 6'h00, 6'h3F, 6'h00},
      {1'b1, 6'h3E, 6'h00, 6'h01, 6'h00},
      {1'b1, 6'h3E, 6'h00, 6'h03, 6'h02},
      {1'b1, 6'h00, 6'h3F, 6'h3F, 6'h00},
      {1'b1, 6'h3F, 6'h3F, 6'h28, 6'h08},
      {1'b1, 6'h3F, 6'h3F, 6'h00, 6'h00}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      poll = 0; ret = 0; reti = 0;
      tick();
      rst_n = 1'b1;
      tick();
   endtask

   // Poll one cycle; check ack one cycle later, then let the sequence finish.
   task automatic take(input string tag, input logic [15:0] p, input logic [5:0] exp_ack);
      pc = p; poll = 1'b1;
      tick();
      poll = 1'b0;
      chk({tag, " ack"}, 32'(ack), 32'(exp_ack));
      if (exp_ack != 0) begin
         tick(); tick();
      end else begin
         tick();
      end
   endtask

   task automatic strobe_reti();
      reti = 1'b1;
      tick();
      reti = 1'b0;
      tick(); tick();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      @(negedge clk);

      // R1 R2 R3 R5: arbitration table
      for (int r = 0; r < 10; r++) begin
         logic [5:0] exp_a;
         int idx;
         do_reset();
         glb  = TBL[r][24];
         en   = TBL[r][23:18];
         prio = TBL[r][17:12];
         req  = TBL[r][11:6];
         exp_a = TBL[r][5:0];
         pc = 16'h4000; poll = 1'b1;
         tick();
         poll = 1'b0;
         chk($sformatf("R1 R2 R3 row%0d ack", r), 32'(ack), 32'(exp_a));
         tick();
         chk($sformatf("R3 row%0d ack width", r), 32'(ack), 0);
         if (exp_a != 0) begin
            idx = 0;
            for (int b = 0; b < 6; b++) if (exp_a[b]) idx = b;
            chk($sformatf("R5 row%0d vector", r), 32'({pc_load, pc_val}), 32'({1'b1, 16'(3 + 8 * idx)}));
         end
         tick();
      end

      // R10: reset state
      glb = 0; req = 0; en = 0; prio = 0;
      do_reset();
      chk("R10 sp", 32'(sp), 7);
      chk("R10 insvc", 32'(insvc), 0);
      chk("R10 busy/ack/strobes", 32'({busy, ack, we, re, pc_load}), 0);

      // R4 R5: low-level call on source 1
      glb = 1; en = 6'h3F; prio = 6'h00; req = 6'h02;
      pc = 16'h1234; poll = 1'b1;
      tick();
      poll = 1'b0;
      chk("R3 ack src1", 32'(ack), 32'h02);
      chk("R4 first write", 32'({we, addr, wdata}), 32'({1'b1, 8'd8, 8'h34}));
      chk("R6 low set", 32'(insvc), 32'h1);
      tick();
      chk("R4 second write", 32'({we, addr, wdata}), 32'({1'b1, 8'd9, 8'h12}));
      chk("R5 vector src1", 32'({pc_load, pc_val}), 32'({1'b1, 16'h000B}));
      tick();
      chk("R4 sp after call", 32'({busy, sp}), 32'({1'b0, 8'd9}));
      chk("R4 stack bytes", 32'({mem[9], mem[8]}), 32'h1234);

      // R6: low in service blocks another low request
      req = 6'h03;
      take("R6 low blocked", 16'h2000, 6'h00);

      // R6: high preempts low
      req = 6'h13; prio = 6'h10;
      take("R6 high preempts", 16'hBEEF, 6'h10);
      chk("R6 both in service", 32'(insvc), 32'h3);
      chk("R4 sp nested", 32'(sp), 11);

      // R6: high in service blocks high
      req = 6'h33; prio = 6'h30;
      take("R6 high blocked", 16'h3000, 6'h00);

      // R8 R9: plain return, strobes during the pop are ignored
      ret = 1'b1;
      tick();
      ret = 1'b0; poll = 1'b1; reti = 1'b1;
      chk("R8 pop hi addr", 32'({re, addr}), 32'({1'b1, 8'd11}));
      tick();
      poll = 1'b0; reti = 1'b0;
      chk("R8 restored pc", 32'({pc_load, pc_val}), 32'({1'b1, 16'hBEEF}));
      chk("R9 no ack while busy", 32'(ack), 0);
      tick();
      chk("R8 insvc kept", 32'(insvc), 32'h3);
      chk("R8 R9 sp after ret", 32'({busy, sp, ack}), 32'({1'b0, 8'd9, 6'h00}));

      // R8: level still blocks after a plain return
      take("R8 still blocked", 16'h3100, 6'h00);

      // R7: interrupt-return clears high, restores the low routine PC
      reti = 1'b1;
      tick();
      reti = 1'b0;
      chk("R7 high cleared", 32'(insvc), 32'h1);
      chk("R7 pop hi addr", 32'({re, addr}), 32'({1'b1, 8'd9}));
      tick();
      chk("R7 restored pc", 32'({pc_load, pc_val}), 32'({1'b1, 16'h1234}));
      tick();
      chk("R7 sp after reti", 32'(sp), 7);

      // R6 R2: preemption again, lowest index of the high level wins
      take("R6 R2 preempt again", 16'h5555, 6'h10);
      strobe_reti();
      chk("R7 reti leaves low", 32'(insvc), 32'h1);
      strobe_reti();
      chk("R7 reti clears low", 32'(insvc), 32'h0);

      // R1: after everything cleared a low request is taken again
      req = 6'h02; prio = 6'h00;
      take("R1 low after clear", 16'h0100, 6'h02);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule